// File: doc/BRIEF.md
# Power-Detect Reset Sequencer

This block turns two active-low power-health signals into a clean system reset for a chip running from its crystal clock. A power-fail input clears a 20-bit delay counter asynchronously. The counter runs only while both the power-fail and the power-down inputs report healthy power. Internal reset is released once the count reaches one of two limits, and a delay-select pin picks the limit. The long limit gives a crystal oscillator time to settle. The short limit serves boards that supply an external clock that is already stable.

While internal reset is active, the block forces the chip's shared pins into a safe state. Bus and GPIO directions are forced to input, the read and write strobes are held inactive, and the oscillator enable is held on. The block also accepts a watchdog request for the CPU, with an enable that can turn that request off. A watchdog reset always lasts the short reset length, so the CPU always gets its minimum reset time.

Top module: `pwr_reset_seq`

## Requirements
- R1: While pfail_n is low, sys_rst, cpu_rst and all four safe-state outputs are 1 and the delay count is zero. This holds asynchronously, without waiting for a clock edge.
- R2: With long_delay=1 and pdown_n high, sys_rst falls on the (LONG_CYC+4)th rising clock edge after pfail_n rises. LONG_CYC is 294912 by default. The extra edges are two for synchronising pfail_n and two for synchronising the release.
- R3: With long_delay=0 and pdown_n high, sys_rst falls on the (SHORT_CYC+4)th rising edge after pfail_n rises. SHORT_CYC is 288 by default.
- R4: Once the count reaches the selected limit it stops there. sys_rst stays 0 for as long as both power inputs stay high.
- R5: A low pdown_n drives sys_rst to 1 at once, with no clock edge needed. While pdown_n is low the count holds its value and is not cleared. Each edge that samples pdown_n low delays release by one edge. After pdown_n returns high with the count already at its limit, sys_rst falls on the second edge.
- R6: A pfail_n low pulse of any width, even one between two clock edges, sets sys_rst to 1 and restarts the full sequence. With long_delay=0, release then comes SHORT_CYC+4 edges after the pulse ends.
- R7: bus_in_force, gpio_in_force, strobe_hold and osc_on are 1 whenever sys_rst is 1, and 0 whenever sys_rst is 0.
- R8: cpu_rst is 1 whenever sys_rst is 1.
- R9: A watchdog request is accepted when wd_req=1 and wd_en=1 on an edge where sys_rst was 0. After that edge, cpu_rst is 1 for exactly SHORT_CYC clock cycles. A new accepted request during that time restarts the full length.
- R10: With wd_en=0, wd_req has no effect and cpu_rst stays equal to sys_rst.
- R11: A request sampled on an edge where sys_rst was still 1 is dropped. This includes the very edge on which reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal system clock |
| pfail_n | input | 1 | Power-fail detect, low = failing; asynchronously clears the sequence |
| pdown_n | input | 1 | Power-down detect, low = not healthy; pauses the count |
| long_delay | input | 1 | 1 selects the long release count, 0 the short one |
| wd_req | input | 1 | Watchdog CPU reset request, synchronous |
| wd_en | input | 1 | 1 lets wd_req reset the CPU |
| sys_rst | output | 1 | Internal system reset, active high |
| cpu_rst | output | 1 | CPU reset: system reset or watchdog reset |
| bus_in_force | output | 1 | Forces the data bus direction to input |
| gpio_in_force | output | 1 | Forces GPIO directions to input |
| strobe_hold | output | 1 | Holds the read and write strobes inactive |
| osc_on | output | 1 | Holds the on-chip oscillator enabled |

## Verification
Reset release and a watchdog request can fall on the same clock edge, and the design must drop that request. The bench restarts the sequence with a short pfail_n pulse placed between two edges. It then drives wd_req high so that the request is sampled exactly on the computed release edge. It requires cpu_rst to stay 0 after that edge. It keeps the request high for one more edge and requires the watchdog pulse to start there and to last the full short length. Random watchdog traffic with a randomly toggled enable is then compared cycle by cycle against a countdown model kept in the bench.

// File: rtl/prs_pkg.sv
package prs_pkg;
  // Count at which internal reset may release for a given delay selection.
  function automatic int unsigned sel_limit(input logic lng, input int unsigned long_cyc,
                                            input int unsigned short_cyc);
    return lng ? long_cyc : short_cyc;
  endfunction

  // Largest limit either selection can reach.
  function automatic int unsigned max_limit(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  // Assertion is immediate through arst_n; release walks through STAGES flops.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/prs_delay_cnt.sv
module prs_delay_cnt #(
  parameter int          CNT_W     = 20,
  parameter int unsigned LONG_CYC  = 294912,
  parameter int unsigned SHORT_CYC = 288
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run,
  input  logic             long_sel,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  import prs_pkg::*;

  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(sel_limit(long_sel, LONG_CYC, SHORT_CYC));
  assign done  = (cnt >= limit);

  // Saturating up-counter: it never wraps, so a released reset cannot re-assert on its own.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                 cnt <= '0;
    else if (run && cnt < limit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prs_wdog.sv
module prs_wdog #(
  parameter int unsigned LEN = 288
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold,
  input  logic req,
  input  logic en,
  output logic busy
);
  localparam int WD_W = $clog2(LEN + 1);

  logic [WD_W-1:0] left;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)           left <= '0;
    else if (hold)         left <= '0;
    else if (req && en)    left <= WD_W'(LEN);
    else if (left != '0)   left <= left - 1'b1;
  end

  assign busy = (left != '0);
endmodule

// File: rtl/pwr_reset_seq.sv
module pwr_reset_seq #(
  parameter int          CNT_W     = 20,
  parameter int unsigned LONG_CYC  = 294912,
  parameter int unsigned SHORT_CYC = 288,
  parameter int          SYNC_N    = 2
) (
  input  logic clk,
  input  logic pfail_n,
  input  logic pdown_n,
  input  logic long_delay,
  input  logic wd_req,
  input  logic wd_en,
  output logic sys_rst,
  output logic cpu_rst,
  output logic bus_in_force,
  output logic gpio_in_force,
  output logic strobe_hold,
  output logic osc_on
);
  // Named internal events, also observed by the bound checker.
  logic             pf_ok;
  logic             run_w;
  logic [CNT_W-1:0] cnt_w;
  logic             done_w;
  logic             rel_ok;
  logic             wd_busy_w;

  prs_sync #(.STAGES(SYNC_N)) u_pf_sync (
    .clk(clk), .arst_n(pfail_n), .d(1'b1), .q(pf_ok)
  );

  assign run_w = pf_ok & pdown_n;

  prs_delay_cnt #(.CNT_W(CNT_W), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_cnt (
    .clk(clk), .arst_n(pfail_n), .run(run_w), .long_sel(long_delay),
    .cnt(cnt_w), .done(done_w)
  );

  prs_sync #(.STAGES(SYNC_N)) u_rel_sync (
    .clk(clk), .arst_n(pfail_n), .d(done_w & pdown_n), .q(rel_ok)
  );

  assign sys_rst = ~(rel_ok & pdown_n & pfail_n);

  prs_wdog #(.LEN(SHORT_CYC)) u_wdog (
    .clk(clk), .arst_n(pfail_n), .hold(sys_rst), .req(wd_req), .en(wd_en),
    .busy(wd_busy_w)
  );

  assign cpu_rst       = sys_rst | wd_busy_w;
  assign bus_in_force  = sys_rst;
  assign gpio_in_force = sys_rst;
  assign strobe_hold   = sys_rst;
  assign osc_on        = sys_rst;
endmodule

// File: rtl/pwr_reset_seq_chk.sv
module pwr_reset_seq_chk #(
  parameter int          CNT_W     = 20,
  parameter int unsigned LONG_CYC  = 294912,
  parameter int unsigned SHORT_CYC = 288
) (
  input logic             clk,
  input logic             pfail_n,
  input logic             pdown_n,
  input logic             wd_req,
  input logic             wd_en,
  input logic             sys_rst,
  input logic             cpu_rst,
  input logic             bus_in_force,
  input logic             gpio_in_force,
  input logic             strobe_hold,
  input logic             osc_on,
  input logic             done_w,
  input logic             wd_busy_w,
  input logic [CNT_W-1:0] cnt_w
);
  localparam int unsigned LIM_MAX = prs_pkg::max_limit(LONG_CYC, SHORT_CYC);

  // R1
  always @(posedge clk) if (!pfail_n) async_clr_chk: assert (sys_rst && cnt_w == '0);

  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    cnt_w <= CNT_W'(LIM_MAX));

  // R5
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    !pdown_n |=> $stable(cnt_w));

  // R5
  pdown_fast_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    !pdown_n |-> sys_rst);

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    $fell(sys_rst) |-> $past(done_w, 2));

  // R7
  safe_on_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    sys_rst |-> (bus_in_force && gpio_in_force && strobe_hold && osc_on));

  // R7
  safe_off_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    !sys_rst |-> !(bus_in_force || gpio_in_force || strobe_hold || osc_on));

  // R8
  cpu_cover_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    sys_rst |-> cpu_rst);

  // R9
  wd_start_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    (wd_req && wd_en && !sys_rst) |=> (cpu_rst && wd_busy_w));

  // R10
  wd_off_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    (!wd_en && !wd_busy_w && !sys_rst) |=> (cpu_rst == sys_rst));

  // R11
  wd_ignore_chk: assert property (@(posedge clk) disable iff (!pfail_n)
    sys_rst |=> !wd_busy_w);
endmodule

bind pwr_reset_seq pwr_reset_seq_chk #(
  .CNT_W(CNT_W), .LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)
) u_chk (
  .clk(clk), .pfail_n(pfail_n), .pdown_n(pdown_n), .wd_req(wd_req), .wd_en(wd_en),
  .sys_rst(sys_rst), .cpu_rst(cpu_rst), .bus_in_force(bus_in_force),
  .gpio_in_force(gpio_in_force), .strobe_hold(strobe_hold), .osc_on(osc_on),
  .done_w(done_w), .wd_busy_w(wd_busy_w), .cnt_w(cnt_w)
);

// File: tb/pwr_reset_seq_bench.sv
`timescale 1ns/1ps
module pwr_reset_seq_bench;
  localparam int CNT_W = 20;
  localparam int LONG  = 1000;
  localparam int SHORT = 288;

  logic clk = 1'b0;
  logic pfail_n, pdown_n, long_delay, wd_req, wd_en;
  logic sys_rst, cpu_rst, bus_in_force, gpio_in_force, strobe_hold, osc_on;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;
  bit ended   = 1'b0;

  always #2.5 clk = ~clk;

  pwr_reset_seq #(.CNT_W(CNT_W), .LONG_CYC(LONG), .SHORT_CYC(SHORT)) u_pwr_reset_seq (
    .clk(clk), .pfail_n(pfail_n), .pdown_n(pdown_n), .long_delay(long_delay),
    .wd_req(wd_req), .wd_en(wd_en), .sys_rst(sys_rst), .cpu_rst(cpu_rst),
    .bus_in_force(bus_in_force), .gpio_in_force(gpio_in_force),
    .strobe_hold(strobe_hold), .osc_on(osc_on)
  );

  // Expected release distance, counted in rising edges after pfail_n rises.
  function automatic int rel_edges(input bit lng);
    return (lng ? LONG : SHORT) + 2 + 2;
  endfunction

  // Next watchdog countdown value, restated from R9.
  function automatic int wd_next(input int cur, input bit req, input bit en);
    if (req && en) return SHORT;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic count_release(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (sys_rst && n < 5000);
  endtask

  task automatic count_cpu_high(output int n);
    n = 0;
    while (cpu_rst && n < 5000) begin
      n++; @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int exp_wd;
    bit r_req, r_en;
    void'($urandom(32'd1575));
    pfail_n = 1'b1; pdown_n = 1'b1; long_delay = 1'b1; wd_req = 1'b0; wd_en = 1'b1;
    #1 pfail_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 / R7 / R8 reset state
    chk("R1 sys_rst in reset", sys_rst, 1);
    chk("R8 cpu_rst in reset", cpu_rst, 1);
    chk("R7 safe outputs in reset",
        {bus_in_force, gpio_in_force, strobe_hold, osc_on}, 4'hF);

    // R2 long delay
    pfail_n = 1'b1;
    count_release(n);
    chk("R2 long release edges", n, rel_edges(1'b1));
    chk("R7 safe outputs released",
        {bus_in_force, gpio_in_force, strobe_hold, osc_on}, 4'h0);

    // R1 async clear, then R3 short delay
    @(negedge clk); #1 pfail_n = 1'b0; #0.5;
    chk("R1 async assert", sys_rst, 1);
    @(negedge clk); long_delay = 1'b0; pfail_n = 1'b1;
    count_release(n);
    chk("R3 short release edges", n, rel_edges(1'b0));

    // R4 saturation: stays released
    n = 0;
    repeat (3000) begin @(negedge clk); if (sys_rst) n++; end
    chk("R4 stays released", n, 0);

    // R5 immediate assert on pdown_n, release two edges after it returns
    @(negedge clk); #1 pdown_n = 1'b0; #0.5;
    chk("R5 pdown immediate", sys_rst, 1);
    @(negedge clk); pdown_n = 1'b1;
    count_release(n);
    chk("R5 release after pdown with count held", n, 2);

    // R5 pdown low mid-count delays release by its low edges
    @(negedge clk); #1 pfail_n = 1'b0; #1 pfail_n = 1'b1;
    fork
      begin
        repeat (100) @(negedge clk);
        pdown_n = 1'b0;
        repeat (37) @(negedge clk);
        pdown_n = 1'b1;
      end
      count_release(n);
    join
    chk("R5 pause postpones release", n, rel_edges(1'b0) + 37);

    // R6 narrow pfail pulse between edges restarts full sequence
    @(negedge clk); #1 pfail_n = 1'b0; #1 pfail_n = 1'b1; #0.1;
    chk("R6 narrow pulse asserts reset", sys_rst, 1);
    count_release(n);
    chk("R6 restart release edges", n, rel_edges(1'b0));

    // R9 single watchdog request
    @(negedge clk); wd_req = 1'b1;
    @(negedge clk); wd_req = 1'b0;
    count_cpu_high(n);
    chk("R9 watchdog length", n, SHORT);

    // R9 retrigger reloads
    @(negedge clk); wd_req = 1'b1;
    @(negedge clk); wd_req = 1'b0;
    repeat (99) @(negedge clk);
    wd_req = 1'b1;
    @(negedge clk); wd_req = 1'b0;
    n = 0;
    count_cpu_high(n);
    chk("R9 retrigger length", n, SHORT);

    // R10 disabled request ignored
    @(negedge clk); wd_en = 1'b0; wd_req = 1'b1;
    n = 0;
    repeat (5) begin @(negedge clk); if (cpu_rst) n++; end
    wd_req = 1'b0; wd_en = 1'b1;
    chk("R10 disabled request", n, 0);

    // R11 request during reset and on the release edge
    @(negedge clk); #1 pfail_n = 1'b0; #1 pfail_n = 1'b1;
    repeat (10) @(negedge clk);
    wd_req = 1'b1;
    @(negedge clk); wd_req = 1'b0;
    repeat (rel_edges(1'b0) - 12) @(negedge clk);
    wd_req = 1'b1;                 // sampled on the release edge
    @(negedge clk);
    chk("R11 released on expected edge", sys_rst, 0);
    chk("R11 release-edge request dropped", cpu_rst, 0);
    @(negedge clk); wd_req = 1'b0; // accepted on the edge after release
    chk("R9 request after release", cpu_rst, 1);
    count_cpu_high(n);
    chk("R9 post-release length", n, SHORT);

    // R9 / R10 random traffic against countdown model
    exp_wd = 0;
    for (int i = 0; i < 3000; i++) begin
      r_req = ($urandom_range(0, 59) == 0);
      r_en  = ($urandom_range(0, 3) != 0);
      wd_req = r_req; wd_en = r_en;
      @(negedge clk);
      exp_wd = wd_next(exp_wd, r_req, r_en);
      chk("R9 R10 random cpu_rst", cpu_rst, (exp_wd != 0));
    end
    wd_req = 1'b0; wd_en = 1'b1;

    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule